// File: doc/BRIEF.md
# Tile-Stitching ReLU Max-Pool Unit

This unit sits behind a convolution array and in front of an output buffer. Each time the array signals that an output tile is finished, the unit asks a partial-sum buffer for that tile. The buffer answers with a transfer indication and then streams the tile's wide signed sums. As each sum is written into an internal region buffer, the unit applies ReLU and narrows it to a saturated 16-bit value.

Four consecutive tiles fill the four quadrants of one stitched region. Once the fourth tile is in, the unit announces that pooling is ready. It then scans the region with 2x2 windows at stride 2 and returns one maximum every four cycles. After the last window it returns to waiting for the next first tile.

Top module: `tile_stitch_pool`

## Requirements
- R1: While reset is held (rst_n low), psum_req_o, pool_rdy_o and pool_vld_o are low.
- R2: psum_req_o rises in the cycle after tile_done_i is sampled high while the unit waits for a tile. It stays high until psum_xfer_i is sampled and is low from the next cycle.
- R3: After a tile's TILE_W*TILE_H valid beats (psum_vld_i high) are stored, the unit waits. psum_req_o stays low until a new tile_done_i.
- R4: A negative partial sum (bit 47 set) is stored as 0 (ReLU).
- R5: A non-negative sum above 32767 is stored as 32767. Any other non-negative sum keeps its value in 16 bits.
- R6: Beats of a tile arrive in raster order (column fastest). Tile k (k = 0..3, counted from the first tile after idle) goes to the quadrant at quadrant row k/2 and quadrant column k%2.
- R7: pool_rdy_o is a one-cycle pulse in the cycle after the last beat of the fourth tile is sampled.
- R8: Each pool_data_o is the maximum of one 2x2 window at stride 2 over the 2*TILE_H by 2*TILE_W region. Windows come in raster order, TILE_W*TILE_H results per region.
- R9: The first pool_vld_o pulse comes 4 clock edges after the edge that samples the last beat. Each later result comes exactly 4 edges after the one before, and pool_vld_o is never high two cycles in a row.
- R10: tile_done_i is ignored while a tile is being requested or received and while pooling. After pooling, the next tile is placed as tile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tile_done_i | input | 1 | Convolution array has finished a tile |
| psum_req_o | output | 1 | Request for the finished tile's sums |
| psum_xfer_i | input | 1 | Partial-sum buffer accepts the request; data starts next cycle |
| psum_vld_i | input | 1 | psum_data_i carries a valid sum |
| psum_data_i | input | PSUM_W (48) | Signed partial sum |
| pool_rdy_o | output | 1 | One-cycle pulse: stitched region complete, pooling starts |
| pool_vld_o | output | 1 | pool_data_o carries a pooled result |
| pool_data_o | output | OUT_W (16) | Pooled maximum |

## Verification
The request is due in the cycle after tile_done_i is sampled. It is due to drop in the cycle after psum_xfer_i is sampled. pool_rdy_o is due in the cycle after the last beat, and pooled results are due 4 edges after that beat and then every 4 edges. The bench keeps a free-running edge counter and records the count at the edge that takes the last beat. The monitor samples on the falling edge and compares each pooled result against both the next value in the scoreboard queue and the edge count at which it was due. The three regions exercise the saturation, ReLU and quadrant-placement rules separately. Stray tile_done_i pulses are driven during reception and during pooling to confirm they are ignored.

// File: rtl/tsp_pkg.sv
// Shared types for the tile-stitching pool unit.
package tsp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for the first tile of a region
        ST_REQ,    // request raised, waiting for the transfer indication
        ST_RECV,   // storing beats of the current tile
        ST_WAIT,   // tile stored, waiting for the next tile_done
        ST_POOL    // scanning the stitched region
    } tsp_state_e;
endpackage

// File: rtl/tsp_relu_sat.sv
// ReLU followed by saturating narrowing of a signed wide sum.
// Assumes IN_W > OUT_W. The output is always non-negative.
module tsp_relu_sat #(
    parameter int IN_W  = 48,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0] din,
    output logic [OUT_W-1:0]       dout
);
    localparam logic signed [IN_W-1:0] LIM = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};

    // Clamp negatives to zero and large positives to the largest positive code.
    always_comb begin
        if (din[IN_W-1])
            dout = '0;
        else if (din > LIM)
            dout = {1'b0, {(OUT_W-1){1'b1}}};
        else
            dout = din[OUT_W-1:0];
    end
endmodule

// File: rtl/tsp_pool_buf.sv
// Region buffer: one synchronous write port and one asynchronous read port.
// Assumes the writer and the reader never address the same entry in the same cycle.
module tsp_pool_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one element per cycle when enabled.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Read the addressed element combinationally.
    assign rdata = mem[raddr];
endmodule

// File: rtl/tsp_pool_cmp.sv
// Sequential 2x2 max comparator: one window element per cycle, phases 0..3.
// Phase 0 loads, phases 1 and 2 compare, phase 3 compares and registers the result.
// Assumes the elements are non-negative (unsigned compare).
module tsp_pool_cmp #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    phase,
    input  logic [DW-1:0] elem,
    output logic [DW-1:0] max_o,
    output logic          vld_o
);
    logic [DW-1:0] run_max;

    // Track the running maximum and emit it at the end of each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_max <= '0;
            max_o   <= '0;
            vld_o   <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (en) begin
                unique case (phase)
                    2'd0: run_max <= elem;
                    2'd3: begin
                        max_o <= (elem > run_max) ? elem : run_max;
                        vld_o <= 1'b1;
                    end
                    default: if (elem > run_max) run_max <= elem;
                endcase
            end
        end
    end
endmodule

// File: rtl/tile_stitch_pool.sv
// Tile-stitching ReLU max-pool unit.
// Collects four tiles of TILE_H x TILE_W sums into a 2x2 quadrant region, then
// max-pools the region with 2x2 windows at stride 2, one result every 4 cycles.
// Assumes TILE_W and TILE_H are at least 2, and that the partial-sum buffer sends
// exactly TILE_W*TILE_H valid beats after each transfer indication.
module tile_stitch_pool
    import tsp_pkg::*;
#(
    parameter int TILE_W = 4,
    parameter int TILE_H = 4,
    parameter int PSUM_W = 48,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tile_done_i,
    output logic              psum_req_o,
    input  logic              psum_xfer_i,
    input  logic              psum_vld_i,
    input  logic [PSUM_W-1:0] psum_data_i,
    output logic              pool_rdy_o,
    output logic              pool_vld_o,
    output logic [OUT_W-1:0]  pool_data_o
);
    localparam int REG_W = 2 * TILE_W;
    localparam int REG_H = 2 * TILE_H;
    localparam int DEPTH = REG_W * REG_H;
    localparam int AW    = $clog2(DEPTH);
    localparam int RXW   = $clog2(REG_W);
    localparam int RYW   = $clog2(REG_H);

    tsp_state_e     state;
    logic [1:0]     tile_cnt;
    logic [RXW-1:0] px, ox;
    logic [RYW-1:0] py, oy;
    logic [1:0]     phase;
    logic           rdy_q;
    logic           last_pix, last_win, wr_en;
    logic [AW-1:0]  wr_addr, rd_addr;
    logic [OUT_W-1:0] wr_val, rd_val;

    assign last_pix = (px == RXW'(TILE_W-1)) && (py == RYW'(TILE_H-1));
    assign last_win = (ox == RXW'(TILE_W-1)) && (oy == RYW'(TILE_H-1));
    assign wr_en    = (state == ST_RECV) && psum_vld_i;

    // Place the incoming pixel inside the quadrant chosen by the tile index.
    always_comb begin
        wr_addr = AW'((int'(py) + (tile_cnt[1] ? TILE_H : 0)) * REG_W
                      + int'(px) + (tile_cnt[0] ? TILE_W : 0));
    end

    // Address the window element selected by the comparator phase.
    always_comb begin
        rd_addr = AW'((2 * int'(oy) + int'(phase[1])) * REG_W
                      + 2 * int'(ox) + int'(phase[0]));
    end

    tsp_relu_sat #(.IN_W(PSUM_W), .OUT_W(OUT_W)) u_relu (
        .din  (psum_data_i),
        .dout (wr_val)
    );

    tsp_pool_buf #(.DW(OUT_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_val),
        .raddr (rd_addr),
        .rdata (rd_val)
    );

    tsp_pool_cmp #(.DW(OUT_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_POOL),
        .phase (phase),
        .elem  (rd_val),
        .max_o (pool_data_o),
        .vld_o (pool_vld_o)
    );

    // Sequence request, reception, stitching and the pooling scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tile_cnt <= '0;
            px       <= '0;
            py       <= '0;
            ox       <= '0;
            oy       <= '0;
            phase    <= '0;
            rdy_q    <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            unique case (state)
                ST_IDLE, ST_WAIT: begin
                    if (tile_done_i) state <= ST_REQ;
                end
                ST_REQ: begin
                    if (psum_xfer_i) state <= ST_RECV;
                end
                ST_RECV: begin
                    if (psum_vld_i) begin
                        if (last_pix) begin
                            px <= '0;
                            py <= '0;
                            if (tile_cnt == 2'd3) begin
                                tile_cnt <= '0;
                                rdy_q    <= 1'b1;
                                state    <= ST_POOL;
                            end else begin
                                tile_cnt <= tile_cnt + 2'd1;
                                state    <= ST_WAIT;
                            end
                        end else if (px == RXW'(TILE_W-1)) begin
                            px <= '0;
                            py <= py + RYW'(1);
                        end else begin
                            px <= px + RXW'(1);
                        end
                    end
                end
                ST_POOL: begin
                    phase <= phase + 2'd1;
                    if (phase == 2'd3) begin
                        if (last_win) begin
                            ox    <= '0;
                            oy    <= '0;
                            state <= ST_IDLE;
                        end else if (ox == RXW'(TILE_W-1)) begin
                            ox <= '0;
                            oy <= oy + RYW'(1);
                        end else begin
                            ox <= ox + RXW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign psum_req_o = (state == ST_REQ);
    assign pool_rdy_o = rdy_q;
endmodule

// File: rtl/tile_stitch_pool_chk.sv
// Protocol and timing checker for tile_stitch_pool, attached by bind.
module tile_stitch_pool_chk
    import tsp_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tile_done_i,
    input logic             psum_xfer_i,
    input logic             psum_req_o,
    input logic             pool_rdy_o,
    input logic             pool_vld_o,
    input logic [OUT_W-1:0] pool_data_o,
    input tsp_state_e       state
);
    logic [2:0] gap;
    logic       seen;

    // Count edges since the last pooled result, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (pool_vld_o) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 3'd7) begin
            gap <= gap + 3'd1;
        end
    end

    assert_no_reset_outputs_R1: assert property (@(posedge clk)
        !rst_n |=> (!psum_req_o && !pool_vld_o && !pool_rdy_o) || !rst_n);

    assert_req_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_done_i && (state == ST_IDLE || state == ST_WAIT)) |=> psum_req_o);

    assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (psum_req_o && psum_xfer_i) |=> !psum_req_o);

    assert_req_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psum_req_o) |-> $past(tile_done_i));

    assert_relu_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pool_vld_o |-> !pool_data_o[OUT_W-1]);

    assert_rdy_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pool_rdy_o |=> !pool_rdy_o);

    assert_vld_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pool_vld_o |=> !pool_vld_o);

    assert_vld_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_vld_o && seen && gap != 3'd7) |-> gap == 3'd3);

    assert_no_req_in_pool_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POOL) |=> !psum_req_o);
endmodule

bind tile_stitch_pool tile_stitch_pool_chk #(.OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tile_done_i (tile_done_i),
    .psum_xfer_i (psum_xfer_i),
    .psum_req_o  (psum_req_o),
    .pool_rdy_o  (pool_rdy_o),
    .pool_vld_o  (pool_vld_o),
    .pool_data_o (pool_data_o),
    .state       (state)
);

// File: tb/tile_stitch_pool_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver fills an expected queue, the monitor pops and compares.
module tile_stitch_pool_tb;
    localparam int TW = 4, TH = 4, PW = 48, OW = 16;
    localparam int NPIX = TW * TH;
    localparam int NOUT = TW * TH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tile_done_i = 1'b0;
    logic          psum_xfer_i = 1'b0;
    logic          psum_vld_i = 1'b0;
    logic [PW-1:0] psum_data_i = '0;
    logic          psum_req_o, pool_rdy_o, pool_vld_o;
    logic [OW-1:0] pool_data_o;

    always #4 clk = ~clk;

    tile_stitch_pool #(.TILE_W(TW), .TILE_H(TH), .PSUM_W(PW), .OUT_W(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tile_done_i(tile_done_i), .psum_req_o(psum_req_o),
        .psum_xfer_i(psum_xfer_i), .psum_vld_i(psum_vld_i), .psum_data_i(psum_data_i),
        .pool_rdy_o(pool_rdy_o), .pool_vld_o(pool_vld_o), .pool_data_o(pool_data_o)
    );

    int     n_chk = 0, n_bad = 0, run_outs = 0;
    longint cyc = 0, last_beat_cyc = 0, prev_vld_cyc = 0;
    bit     first_of_run = 0, finished = 0;
    string  run_tag = "R8";
    longint exp_q[$];
    longint region[2*TH][2*TW];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat16(input longint v);
        if (v < 0) return 0;             // R4
        if (v > 32767) return 32767;     // R5
        return v;
    endfunction

    // Mode 0: mixed signs (R4); mode 1: large and boundary values (R5); mode 2: unique ramp (R6).
    function automatic longint gen(input int mode, input int k, input int p);
        case (mode)
            0: return longint'(((k * 37 + p * 13) % 200) - 100);
            1: begin
                if (k == 2 && p == 0) return -(longint'(1) <<< 40);
                case (p % 4)
                    0: return -5000;
                    1: return 32767;
                    2: return 32768 + k * 1000;
                    default: return (longint'(1) <<< 32) + p;
                endcase
            end
            default: return longint'(k * 100 + p);
        endcase
    endfunction

    // Monitor: compare each pooled result with the queue and with its due edge.
    always @(negedge clk) begin
        if (rst_n && pool_vld_o) begin
            if (exp_q.size() == 0) begin
                check(0, "R8 unexpected pooled result", longint'(pool_data_o), -1);
            end else begin
                longint e;
                e = exp_q.pop_front();
                check(longint'(pool_data_o) == e, {run_tag, " pooled value"}, longint'(pool_data_o), e);
            end
            if (first_of_run) begin
                check(cyc == last_beat_cyc + 4, "R9 first result latency", cyc - last_beat_cyc, 4);
                first_of_run = 0;
            end else begin
                check(cyc == prev_vld_cyc + 4, "R9 result cadence", cyc - prev_vld_cyc, 4);
            end
            prev_vld_cyc = cyc;
            run_outs++;
        end
    end

    task automatic run_region(input int mode);
        run_outs = 0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1 tile_done_i = 1'b1;
            @(negedge clk);
            check(psum_req_o == 1'b0, "R3 no request before tile_done", psum_req_o, 0);
            @(posedge clk); #1 tile_done_i = 1'b0;
            @(negedge clk);
            check(psum_req_o == 1'b1, "R2 request one cycle after tile_done", psum_req_o, 1);
            repeat (2) @(posedge clk);
            @(negedge clk);
            check(psum_req_o == 1'b1, "R2 request held until transfer", psum_req_o, 1);
            @(posedge clk); #1 psum_xfer_i = 1'b1;
            @(posedge clk); #1 psum_xfer_i = 1'b0;
            for (int p = 0; p < NPIX; p++) begin
                longint v;
                v = gen(mode, k, p);
                psum_data_i = v[PW-1:0];
                psum_vld_i  = 1'b1;
                tile_done_i = (k == 1 && p == 5);   // R10 stray pulse while receiving
                region[(k / 2) * TH + p / TW][(k % 2) * TW + p % TW] = sat16(v);   // R6
                if (p == 0) begin
                    @(negedge clk);
                    check(psum_req_o == 1'b0, "R2 request drops after transfer", psum_req_o, 0);
                end
                @(posedge clk); #1;
            end
            psum_vld_i  = 1'b0;
            tile_done_i = 1'b0;
            last_beat_cyc = cyc;
            if (k < 3) begin
                @(negedge clk);
                check(psum_req_o == 1'b0, "R10 tile_done ignored during receive", psum_req_o, 0);
                repeat (3) @(posedge clk);
                @(negedge clk);
                check(psum_req_o == 1'b0, "R3 waits after tile stored", psum_req_o, 0);
            end else begin
                for (int oy = 0; oy < TH; oy++)
                    for (int ox = 0; ox < TW; ox++) begin
                        longint m;
                        m = region[2*oy][2*ox];
                        if (region[2*oy][2*ox+1] > m) m = region[2*oy][2*ox+1];
                        if (region[2*oy+1][2*ox] > m) m = region[2*oy+1][2*ox];
                        if (region[2*oy+1][2*ox+1] > m) m = region[2*oy+1][2*ox+1];
                        exp_q.push_back(m);
                    end
                first_of_run = 1;
                @(negedge clk);
                check(pool_rdy_o == 1'b1, "R7 ready pulse after fourth tile", pool_rdy_o, 1);
                @(negedge clk);
                check(pool_rdy_o == 1'b0, "R7 ready is one cycle", pool_rdy_o, 0);
                @(posedge clk); #1 tile_done_i = 1'b1;
                @(posedge clk); #1 tile_done_i = 1'b0;
                @(negedge clk);
                check(psum_req_o == 1'b0, "R10 tile_done ignored while pooling", psum_req_o, 0);
                wait (exp_q.size() == 0);
                repeat (8) @(posedge clk);
                check(run_outs == NOUT, "R8 results per region", run_outs, NOUT);
                @(negedge clk);
                check(psum_req_o == 1'b0, "R10 no request after pooling", psum_req_o, 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(psum_req_o == 1'b0, "R1 request low in reset", psum_req_o, 0);
        check(pool_vld_o == 1'b0, "R1 valid low in reset", pool_vld_o, 0);
        check(pool_rdy_o == 1'b0, "R1 ready low in reset", pool_rdy_o, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        run_tag = "R4 relu";
        run_region(0);
        run_tag = "R5 saturation";
        run_region(1);
        run_tag = "R6 quadrant placement";
        run_region(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule